// File: doc/BRIEF.md
# Glitch-Free Shared Strobe Counter Across Three Clock Domains

This block counts data-valid strobes coming from whichever of three unrelated clock domains is active, and it uses a single counter for the job. Each domain brings its own clock, active-low reset, select line and valid strobe. The select lines are quasi-static and at most one should be high.

The block turns the select lines into one active domain and hands its clock over through a glitch-free switch. The switch uses a break-before-make handshake between the three per-domain enables. The selected domain's reset and valid follow the same enable. The reset reaching the counter is asserted at once and released in step with the output clock.

The count is exposed in the output clock domain. When no domain is selected, the output clock stops low and the counter is held in reset.

Top module: `shared_strobe_counter`

## Requirements
- R1: Select bit 0 is domain A, bit 1 is domain B and bit 2 is domain C. When several select bits are high, the lowest index wins (A over B over C).
- R2: At most one domain enable is high at any time. While domain k is enabled, `clk_o` follows `clk_i[k]`.
- R3: A domain's enable rises only after all other enables have been seen low in its own clock domain. It changes only while its own clock is low, so `clk_o` has no high or low pulse shorter than half the shortest input period.
- R4: With no select bit high, `clk_o` stays low, `rst_no` stays low and `count_o` reads 0.
- R5: The counter reset is asserted at once when the selected domain's reset goes low or no domain is enabled. It is released after two rising edges of `clk_o`. A reset of the selected domain clears `count_o` to 0.
- R6: `count_o` rises by one for each rising edge of `clk_o` at which the selected domain's valid is high. Valid strobes of domains that are not selected are ignored.
- R7: The counter is `CNT_W` bits wide (default 32) and wraps from all-ones to zero.
- R8: Each domain change passes through the reset state, so `count_o` restarts at 0. Strobes that arrive during the change-over may be lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 3 | Domain clocks, bit 0 = A, bit 1 = B, bit 2 = C |
| rst_ni | input | 3 | Active-low asynchronous reset of each domain |
| sel_i | input | 3 | Domain select lines, quasi-static |
| valid_i | input | 3 | Data-valid strobe of each domain, in that domain's clock |
| clk_o | output | 1 | Switched clock of the active domain, low when idle |
| rst_no | output | 1 | Active-low counter reset, released in step with `clk_o` |
| count_o | output | CNT_W | Strobe count, in the `clk_o` domain |

## Verification
The assertions watch three things on every cycle: that the enables stay mutually exclusive, that an enable only rises once the other enables are low, and that the counter steps by exactly one on a sampled valid and holds otherwise. The reset synchronizer is also checked to release only through its first stage.

The pulse-width guarantee on the switched clock can only be shown by the bench's scenarios. So can the priority decode, the idle state, wrapping at a narrow width, clearing on a domain reset, and the rejection of strobes from domains that are not selected. The bench measures every `clk_o` edge against the shortest input half period and compares the counts against the strobes it drove.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  localparam int N_DOM = 3;
  typedef logic [N_DOM-1:0] dom_vec_t;

  // lowest index wins
  function automatic dom_vec_t pick_domain(dom_vec_t sel);
    dom_vec_t res;
    res = '0;
    for (int k = N_DOM - 1; k >= 0; k--) begin
      if (sel[k]) res = dom_vec_t'(1) << k;
    end
    return res;
  endfunction
endpackage

// File: rtl/ssc_clk_gate.sv
`timescale 1ns/1ps
module ssc_clk_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int N_OTHERS    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [N_OTHERS-1:0] others_i,
  output logic                en_o
);
  logic                   req_gated;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  assign req_gated = req_i & ~(|others_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_gated};
  end

  // enable moves only while this clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= sync_q[SYNC_STAGES-1];
  end

  assign en_o = en_q;

  p_handoff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> (others_i == '0))
    else $error("R3 enable rose while another domain enabled");
endmodule

// File: rtl/ssc_rst_sync.sv
`timescale 1ns/1ps
module ssc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(sync_q[STAGES-2]))
    else $error("R5 reset released without passing first stage");
endmodule

// File: rtl/ssc_counter.sv
`timescale 1ns/1ps
module ssc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("R6 count did not step by one");

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q))
    else $error("R6 count moved without strobe");
endmodule

// File: rtl/shared_strobe_counter.sv
`timescale 1ns/1ps
module shared_strobe_counter
  import ssc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic [2:0]       clk_i,
  input  logic [2:0]       rst_ni,
  input  logic [2:0]       sel_i,
  input  logic [2:0]       valid_i,
  output logic             clk_o,
  output logic             rst_no,
  output logic [CNT_W-1:0] count_o
);
  dom_vec_t req;
  dom_vec_t en;
  logic     rst_sel_n;
  logic     valid_sel;

  assign req = pick_domain(sel_i);

  for (genvar k = 0; k < N_DOM; k++) begin : g_dom
    dom_vec_t others_all;
    logic [N_DOM-2:0] others;
    assign others_all = en & ~(dom_vec_t'(1) << k);
    // drop bit k, keep the rest in order
    if (k == 0) begin : g_lo
      assign others = others_all[N_DOM-1:1];
    end else if (k == N_DOM - 1) begin : g_hi
      assign others = others_all[N_DOM-2:0];
    end else begin : g_mid
      assign others = {others_all[N_DOM-1:k+1], others_all[k-1:0]};
    end

    ssc_clk_gate #(
      .SYNC_STAGES(SYNC_STAGES),
      .N_OTHERS   (N_DOM - 1)
    ) i_gate (
      .clk_i   (clk_i[k]),
      .rst_ni  (rst_ni[k]),
      .req_i   (req[k]),
      .others_i(others),
      .en_o    (en[k])
    );
  end

  assign clk_o     = |(clk_i & en);
  assign rst_sel_n = |(rst_ni & en);
  assign valid_sel = |(valid_i & en);

  ssc_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i (clk_o),
    .rst_ni(rst_sel_n),
    .rst_no(rst_no)
  );

  ssc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_o),
    .rst_ni (rst_no),
    .inc_i  (valid_sel),
    .count_o(count_o)
  );

  always_comb begin
    if (!$isunknown(en)) begin
      p_excl_en_r2: assert ($onehot0(en))
        else $error("R2 more than one domain enabled");
    end
  end
endmodule

// File: tb/test_shared_strobe_counter.sv
`timescale 1ns/1ps
module test_shared_strobe_counter;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_PERIOD_B = 14;
  localparam int CLK_PERIOD_C = 22;
  localparam real MIN_PULSE   = CLK_PERIOD / 2.0;
  localparam int CNT_W        = 32;
  localparam int NARROW_W     = 4;
  localparam int SETTLE       = 40 * CLK_PERIOD_C;

  logic [2:0] clk = '0;
  logic [2:0] rst_n = '0;
  logic [2:0] sel = '0;
  logic [2:0] valid = '0;
  logic clk_o, rst_no, clk_o_n, rst_no_n;
  logic [CNT_W-1:0]    count;
  logic [NARROW_W-1:0] count_n;

  int n_chk = 0;
  int n_fail = 0;
  int glitches = 0;
  realtime last_edge = 0.0;

  typedef struct {
    string       tag;
    logic [31:0] exp;
    bit          narrow;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2.0)   clk[0] = ~clk[0];
  always #(CLK_PERIOD_B / 2.0) clk[1] = ~clk[1];
  always #(CLK_PERIOD_C / 2.0) clk[2] = ~clk[2];

  shared_strobe_counter #(.CNT_W(CNT_W)) i_shared_strobe_counter (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .valid_i(valid),
    .clk_o(clk_o), .rst_no(rst_no), .count_o(count)
  );

  shared_strobe_counter #(.CNT_W(NARROW_W)) i_shared_strobe_counter_narrow (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .valid_i(valid),
    .clk_o(clk_o_n), .rst_no(rst_no_n), .count_o(count_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R3 pulse width monitor
  always @(clk_o) begin
    if ($realtime > 1.0) begin
      if (($realtime - last_edge) < MIN_PULSE - 0.01) glitches++;
      last_edge = $realtime;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      #1;
      if (it.narrow) chk(count_n == it.exp[NARROW_W-1:0], it.tag, count_n, it.exp[NARROW_W-1:0]);
      else           chk(count == it.exp, it.tag, count, it.exp);
    end
  end

  task automatic push(input string tag, input int wide_exp, input int narrow_exp);
    exp_t a;
    exp_t b;
    a.tag = tag; a.exp = wide_exp;   a.narrow = 1'b0;
    b.tag = tag; b.exp = narrow_exp; b.narrow = 1'b1;
    exp_q.push_back(a);
    exp_q.push_back(b);
    #5;
  endtask

  task automatic strobe(input int k, input int n);
    repeat (n) begin
      @(negedge clk[k]); valid[k] = 1'b1;
      @(negedge clk[k]); valid[k] = 1'b0;
      @(negedge clk[k]);
    end
  endtask

  task automatic idle_check(input string tag);
    repeat (4) begin
      #7;
      chk(clk_o == 1'b0, {tag, " clk_o low"}, clk_o, 0);
    end
    chk(rst_no == 1'b0, {tag, " rst_no low"}, rst_no, 0);
    chk(count == '0, {tag, " count zero"}, count, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    idle_check("R4 reset");
    rst_n = '1;
    #(SETTLE / 4);
    idle_check("R4 no select");

    // A selected, B strobes must be ignored
    sel = 3'b001;
    #SETTLE;
    chk(rst_no == 1'b1, "R5 released", rst_no, 1);
    push("R8 restart A", 0, 0);
    repeat (3) begin
      @(posedge clk[0]); #1;
      chk(clk_o == 1'b1, "R2 follows A high", clk_o, 1);
      @(negedge clk[0]); #1;
      chk(clk_o == 1'b0, "R2 follows A low", clk_o, 0);
    end
    fork
      strobe(0, 5);
      strobe(1, 6);
    join
    #(CLK_PERIOD * 2);
    push("R6 count A", 5, 5);

    // B and C both selected: B wins
    sel = 3'b110;
    #SETTLE;
    push("R8 restart B", 0, 0);
    fork
      strobe(1, 7);
      strobe(2, 4);
    join
    #(CLK_PERIOD_B * 2);
    push("R1 priority B over C", 7, 7);

    // C only, wrap on narrow instance
    sel = 3'b100;
    #SETTLE;
    strobe(2, 20);
    #(CLK_PERIOD_C * 2);
    push("R7 wrap", 20, 20 % (1 << NARROW_W));

    // reset of selected domain, applied while its clock is low
    @(negedge clk[2]); rst_n[2] = 1'b0;
    #3;
    chk(count == '0, "R5 domain reset clears", count, 0);
    chk(rst_no == 1'b0, "R5 reset asserted", rst_no, 0);
    @(negedge clk[2]); rst_n[2] = 1'b1;
    #SETTLE;
    strobe(2, 3);
    #(CLK_PERIOD_C * 2);
    push("R5 count after reset", 3, 3);

    sel = 3'b000;
    #SETTLE;
    idle_check("R4 deselect");

    wait (exp_q.size() == 0);
    #10;
    chk(glitches == 0, "R3 short pulses on clk_o", glitches, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule